// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with two register frames: a control frame that software uses to configure it and read its status, and a refresh frame whose only job is to take keep-alive writes. The timer keeps no counter of its own. It compares an external 64-bit free-running system count against an absolute deadline that it stores. When the deadline passes the first time, a warning is raised. The deadline then moves one offset period further out. If that second deadline also passes without a refresh, a reset request is raised and held.

A refresh sets the deadline to the current count plus the offset and clears the warning. Three writes count as a refresh: a write of any value to the refresh register, a write to the control/status register, and a write to the offset register. Software can also write the deadline directly as two 32-bit halves. The reset-request status bit survives refreshes, so after a reboot software can read it and see that the watchdog caused the reset. Only the block reset clears it.

Top module: `wdog2s_top`

## Requirements
- R1: After reset, the enable, warning and reset-request status bits are 0, both outputs are low, and the offset and deadline registers read 0.
- R2: Control/status at control-frame byte address 0x000 reads bit 0 = enable, bit 1 = warning status, bit 2 = reset-request status, and 0 in all other bits. The offset is at 0x008. The deadline's low word is at 0x010 and its high word at 0x014.
- R3: A write to refresh-frame address 0x000 sets the deadline to the current count plus the zero-extended offset and clears the warning status. The write data is ignored.
- R4: A control/status write sets enable from data bit 0 and refreshes the timer. An offset write stores the new value and refreshes the timer using that new value.
- R5: When the block is enabled, no refresh occurs, the warning is clear and count >= deadline, the block sets the warning status and reloads the deadline with count plus offset.
- R6: When the block is enabled, no refresh occurs, the warning is set and count >= deadline, the block sets the reset-request status. This status and the reset-request output stay high through refreshes and disable until the block reset.
- R7: While enable is 0, no expiry occurs. The warning output equals warning status AND enable.
- R8: A write to 0x010 or 0x014 replaces that half of the deadline and does not refresh the timer. A refresh in the same cycle takes precedence over it.
- R9: Address 0xFCC in both frames reads the fixed identification value ID_VALUE, and writes to it have no effect. Unmapped addresses read 0.
- R10: A refresh in the same cycle as an expiry takes precedence, so the warning status stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | System count |
| ctl_addr | input | 12 | Control frame byte address |
| ctl_wr | input | 1 | Control frame write strobe |
| ctl_wdata | input | 32 | Control frame write data |
| ctl_rdata | output | 32 | Control frame read data (combinational) |
| rf_addr | input | 12 | Refresh frame byte address |
| rf_wr | input | 1 | Refresh frame write strobe |
| rf_rdata | output | 32 | Refresh frame read data (combinational) |
| ws0_o | output | 1 | Warning interrupt |
| ws1_o | output | 1 | Reset request |

## Verification
The assertions assume the system count rises steadily and never wraps. They also assume that count plus offset stays below 2^64, so the deadline arithmetic never overflows. To keep within this, the stimulus starts the count below 2^32, advances it by 0 to 3 ticks per cycle, and keeps offsets and deadline writes small. Each frame takes at most one write per cycle. Random traffic mixes refreshes, offset, control and deadline writes with idle cycles against a cycle-level reference model.

// File: rtl/wdog2s_pkg.sv
package wdog2s_pkg;
    localparam int CW = 64;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam logic [AW-1:0] A_CTRL  = 12'h000;
    localparam logic [AW-1:0] A_OFS   = 12'h008;
    localparam logic [AW-1:0] A_DLO   = 12'h010;
    localparam logic [AW-1:0] A_DHI   = 12'h014;
    localparam logic [AW-1:0] A_KICK  = 12'h000;
    localparam logic [AW-1:0] A_IDENT = 12'hFCC;

    // bit order matches the control/status register: [2]=rst req, [1]=warn, [0]=enable
    typedef struct packed {
        logic rreq;
        logic warn;
        logic en;
    } wd_stat_t;

    function automatic logic passed(input logic [CW-1:0] cnt, input logic [CW-1:0] dl);
        return cnt >= dl;
    endfunction

    function automatic logic [CW-1:0] deadline(input logic [CW-1:0] cnt, input logic [DW-1:0] ofs);
        return cnt + {{(CW-DW){1'b0}}, ofs};
    endfunction
endpackage

// File: rtl/wdog2s_regs.sv
module wdog2s_regs
    import wdog2s_pkg::*;
#(
    parameter logic [DW-1:0] ID_VALUE = 32'h0201_A5C3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  ctl_addr,
    input  logic           ctl_wr,
    input  logic [DW-1:0]  ctl_wdata,
    input  logic [AW-1:0]  rf_addr,
    input  logic           rf_wr,
    input  wd_stat_t       stat,
    input  logic [CW-1:0]  dl,
    output logic           refresh,
    output logic           en_wr,
    output logic [DW-1:0]  eff_ofs,
    output logic           dlo_wr,
    output logic           dhi_wr,
    output logic [DW-1:0]  ctl_rdata,
    output logic [DW-1:0]  rf_rdata
);
    logic [DW-1:0] ofs_q;
    logic          ofs_wr;

    assign en_wr   = ctl_wr && (ctl_addr == A_CTRL);
    assign ofs_wr  = ctl_wr && (ctl_addr == A_OFS);
    assign dlo_wr  = ctl_wr && (ctl_addr == A_DLO);
    assign dhi_wr  = ctl_wr && (ctl_addr == A_DHI);
    assign refresh = en_wr || ofs_wr || (rf_wr && (rf_addr == A_KICK));
    assign eff_ofs = ofs_wr ? ctl_wdata : ofs_q;

    always_ff @(posedge clk) begin
        if (rst)         ofs_q <= '0;
        else if (ofs_wr) ofs_q <= ctl_wdata;
    end

    always_comb begin
        case (ctl_addr)
            A_CTRL:  ctl_rdata = {{(DW-3){1'b0}}, stat};
            A_OFS:   ctl_rdata = ofs_q;
            A_DLO:   ctl_rdata = dl[DW-1:0];
            A_DHI:   ctl_rdata = dl[CW-1:DW];
            A_IDENT: ctl_rdata = ID_VALUE;
            default: ctl_rdata = '0;
        endcase
    end

    always_comb begin
        rf_rdata = (rf_addr == A_IDENT) ? ID_VALUE : '0;
    end

    // R4
    ofs_store_chk: assert property (@(posedge clk) disable iff (rst)
        ofs_wr |=> (ofs_q == $past(ctl_wdata)));
endmodule

// File: rtl/wdog2s_core.sv
module wdog2s_core
    import wdog2s_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          refresh,
    input  logic          en_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] eff_ofs,
    input  logic          dlo_wr,
    input  logic          dhi_wr,
    output wd_stat_t      stat,
    output logic [CW-1:0] dl
);
    wd_stat_t      st_q;
    logic [CW-1:0] dl_q;
    logic          fire;

    assign fire = st_q.en && passed(cnt, dl_q);
    assign stat = st_q;
    assign dl   = dl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            dl_q <= '0;
        end else begin
            if (en_wr) st_q.en <= wdata[0];
            if (refresh) begin
                dl_q      <= deadline(cnt, eff_ofs);
                st_q.warn <= 1'b0;
            end else if (dlo_wr || dhi_wr) begin
                if (dlo_wr) dl_q[DW-1:0]  <= wdata;
                if (dhi_wr) dl_q[CW-1:DW] <= wdata;
            end else if (fire) begin
                if (!st_q.warn) begin
                    st_q.warn <= 1'b1;
                    dl_q      <= deadline(cnt, eff_ofs);
                end else begin
                    st_q.rreq <= 1'b1;
                end
            end
        end
    end

    // R6
    rreq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.rreq |=> st_q.rreq);
    // R6
    rreq_after_warn_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.rreq) |-> $past(st_q.warn));
    // R3
    refresh_clears_warn_chk: assert property (@(posedge clk) disable iff (rst)
        refresh |=> !st_q.warn);
    // R7
    idle_no_warn_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.en |=> !$rose(st_q.warn));
    // R5
    warn_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.en && !st_q.warn && !refresh && !dlo_wr && !dhi_wr && (cnt >= dl_q))
        |=> (st_q.warn && dl_q == $past(cnt) + {{(CW-DW){1'b0}}, $past(eff_ofs)}));
endmodule

// File: rtl/wdog2s_top.sv
module wdog2s_top
    import wdog2s_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h0201_A5C3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] cnt_i,
    input  logic [11:0] ctl_addr,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata,
    input  logic [11:0] rf_addr,
    input  logic        rf_wr,
    output logic [31:0] rf_rdata,
    output logic        ws0_o,
    output logic        ws1_o
);
    wd_stat_t      stat;
    logic [CW-1:0] dl;
    logic          refresh, en_wr, dlo_wr, dhi_wr;
    logic [DW-1:0] eff_ofs;

    wdog2s_regs #(.ID_VALUE(ID_VALUE)) regs_i (
        .clk(clk), .rst(rst),
        .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .rf_addr(rf_addr), .rf_wr(rf_wr),
        .stat(stat), .dl(dl),
        .refresh(refresh), .en_wr(en_wr), .eff_ofs(eff_ofs),
        .dlo_wr(dlo_wr), .dhi_wr(dhi_wr),
        .ctl_rdata(ctl_rdata), .rf_rdata(rf_rdata)
    );

    wdog2s_core core_i (
        .clk(clk), .rst(rst), .cnt(cnt_i),
        .refresh(refresh), .en_wr(en_wr), .wdata(ctl_wdata),
        .eff_ofs(eff_ofs), .dlo_wr(dlo_wr), .dhi_wr(dhi_wr),
        .stat(stat), .dl(dl)
    );

    assign ws0_o = stat.warn & stat.en;
    assign ws1_o = stat.rreq;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!ws0_o && !ws1_o));
endmodule

// File: tb/wdog2s_top_tb_top.sv
`timescale 1ns/10ps
module wdog2s_top_tb_top;
    localparam logic [31:0] ID = 32'h0201_A5C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt_i = '0;
    logic [11:0] ctl_addr = '0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [11:0] rf_addr = '0;
    logic        rf_wr = 1'b0;
    logic [31:0] rf_rdata;
    logic        ws0_o, ws1_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] cstep = 2'd1;

    logic        m_en, m_ws0, m_ws1;
    logic [63:0] m_dl;
    logic [31:0] m_ofs;

    always #2 clk = ~clk;

    wdog2s_top #(.ID_VALUE(ID)) dut_i (
        .clk(clk), .rst(rst), .cnt_i(cnt_i),
        .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rf_addr(rf_addr), .rf_wr(rf_wr), .rf_rdata(rf_rdata),
        .ws0_o(ws0_o), .ws1_o(ws1_o)
    );

    function automatic logic [63:0] next_dl(input logic [63:0] c, input logic [31:0] o);
        return c + {32'd0, o};
    endfunction

    // reference model step, from the requirements, using inputs present before the edge
    task automatic model_step();
        logic kick, ofsw, ctlw;
        logic [31:0] eo;
        if (rst) begin
            m_en = 0; m_ws0 = 0; m_ws1 = 0; m_dl = '0; m_ofs = '0;
            return;
        end
        ctlw = ctl_wr && ctl_addr == 12'h000;
        ofsw = ctl_wr && ctl_addr == 12'h008;
        kick = ctlw || ofsw || (rf_wr && rf_addr == 12'h000);
        eo   = ofsw ? ctl_wdata : m_ofs;
        if (kick) begin
            m_dl = next_dl(cnt_i, eo); m_ws0 = 0;
        end else if (ctl_wr && (ctl_addr == 12'h010 || ctl_addr == 12'h014)) begin
            if (ctl_addr == 12'h010) m_dl[31:0] = ctl_wdata; else m_dl[63:32] = ctl_wdata;
        end else if (m_en && cnt_i >= m_dl) begin
            if (!m_ws0) begin m_ws0 = 1; m_dl = next_dl(cnt_i, m_ofs); end
            else m_ws1 = 1;
        end
        if (ofsw) m_ofs = ctl_wdata;
        if (ctlw) m_en = ctl_wdata[0];
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        ctl_wr = 0; rf_wr = 0; ctl_addr = 12'h000; rf_addr = 12'h000;
        cnt_i = cnt_i + {62'd0, cstep};
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_ctl(input logic [11:0] a, output logic [31:0] d);
        ctl_addr = a; #0.1; d = ctl_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] cs, lo, hi;
        rd_ctl(12'h000, cs);
        rd_ctl(12'h010, lo);
        rd_ctl(12'h014, hi);
        ctl_addr = 12'h000;
        chk(req, {61'd0, cs[2:0]}, {61'd0, m_ws1, m_ws0, m_en});
        chk(req, {32'd0, cs[31:3]}, 64'd0);
        chk(req, {hi, lo}, m_dl);
        chk(req, {62'd0, ws1_o, ws0_o}, {62'd0, m_ws1, m_ws0 & m_en});
    endtask

    task automatic wr_ctl(input logic [11:0] a, input logic [31:0] d);
        ctl_addr = a; ctl_wdata = d; ctl_wr = 1; tick();
    endtask

    task automatic kick();
        rf_addr = 12'h000; rf_wr = 1; tick();
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd7531));
        rst = 1; tick(); tick(); rst = 0;
        // R1 reset state
        check_all("R1");
        rd_ctl(12'h008, d); chk("R1", {32'd0, d}, 64'd0);

        // R9 identification and unmapped
        rd_ctl(12'hFCC, d); chk("R9", {32'd0, d}, {32'd0, ID});
        rf_addr = 12'hFCC; #0.1; chk("R9", {32'd0, rf_rdata}, {32'd0, ID});
        rf_addr = 12'h000; #0.1; chk("R9", {32'd0, rf_rdata}, 64'd0);
        wr_ctl(12'hFCC, 32'h1234_5678);
        rd_ctl(12'hFCC, d); chk("R9", {32'd0, d}, {32'd0, ID});
        rd_ctl(12'h020, d); chk("R9", {32'd0, d}, 64'd0);
        check_all("R9");

        // R4 offset then enable; R2 map
        cnt_i = {32'd0, $urandom};
        wr_ctl(12'h008, 32'd20);
        rd_ctl(12'h008, d); chk("R4", {32'd0, d}, 64'd20);
        check_all("R4");
        wr_ctl(12'h000, 32'hFFFF_FFF1);
        check_all("R2");

        // R5 first expiry, R6 second expiry
        for (int i = 0; i < 25; i++) begin tick(); check_all("R5"); end
        for (int i = 0; i < 25; i++) begin tick(); check_all("R6"); end
        chk("R6", {63'd0, ws1_o}, 64'd1);
        // R3 refresh clears warning, keeps reset request
        rf_addr = 12'h000; rf_wr = 1; ctl_wdata = 32'hDEAD_BEEF; tick();
        check_all("R3");
        chk("R6", {63'd0, ws1_o}, 64'd1);

        // R10 refresh versus expiry with zero offset
        wr_ctl(12'h008, 32'd0);
        kick();
        check_all("R10");
        tick();
        check_all("R5");

        // R8 deadline writes do not refresh
        wr_ctl(12'h008, 32'd100);
        tick(); check_all("R8");
        wr_ctl(12'h014, cnt_i[63:32]);
        wr_ctl(12'h010, cnt_i[31:0] + 32'd6);
        check_all("R8");
        for (int i = 0; i < 8; i++) begin tick(); check_all("R8"); end
        // R8 refresh and deadline write same cycle: refresh wins
        ctl_addr = 12'h010; ctl_wdata = 32'h5; ctl_wr = 1; rf_wr = 1; rf_addr = 12'h000; tick();
        check_all("R8");

        // R7 disabled: no expiry
        wr_ctl(12'h000, 32'd0);
        cstep = 2'd3;
        for (int i = 0; i < 60; i++) begin tick(); if (i % 10 == 0) check_all("R7"); end
        chk("R7", {63'd0, ws0_o}, 64'd0);
        cstep = 2'd1;

        // R1 only reset clears the reset request
        rst = 1; tick(); rst = 0;
        check_all("R1");

        // random traffic, R5/R6 against model
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom % 10;
            cstep = 2'($urandom % 4);
            case (op)
                0: kick();
                1: wr_ctl(12'h008, $urandom % 48);
                2, 3: wr_ctl(12'h000, {31'd0, ($urandom % 4) != 0});
                4: wr_ctl(12'h010, cnt_i[31:0] + ($urandom % 40));
                5: wr_ctl(12'h014, cnt_i[63:32]);
                default: tick();
            endcase
            check_all("R5/R6 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule